// File: doc/BRIEF.md
# Register-Init Command Sequencer

This block programs a set of registers from a table of 32-bit words held in memory. Software or a boot controller writes the table, gives the sequencer a base address and a length in words, and pulses `start`. The sequencer then reads the table through a port with one cycle of latency and decodes each entry. Depending on the entry, it performs a plain write, a read-modify-write, a masked poll or a write into a selected index space. The register bus uses a request/acknowledge handshake.

Entries follow one another with no gaps. Each begins with a header word whose top four bits give the command kind. A terminator entry ends the run normally. An unknown kind, an entry that runs past the given length, or a poll that never matches ends the run with `error`. Every run ends with `done`, and `exec_count` then holds the number of commands completed.

The register bus follows valid/ready rules. `reg_req` acts as valid and `reg_ack` as ready. Once `reg_req` is raised, every request field holds still until the cycle in which `reg_ack` is seen. The responder may stall for any number of cycles. The table port has no back-pressure.

Top module: `cmdtab_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `reg_req` and `tbl_rd_en` are 0 and `exec_count` is 0.
- R2: The kind is taken from header bits [31:28]. The codes are 0x0 direct write (2 words), 0x2 poll (3 words), 0x3 read-modify-write (3 words), 0x8 indexed write (2 words) and 0xF terminator (1 word). Entries are packed, and the next header follows immediately after the last word of the previous entry.
- R3: A direct write issues one request with `reg_we`=1, `reg_indirect`=0, `reg_addr`= header[27:0] and `reg_wdata`= word 1.
- R4: A read-modify-write reads `reg_addr`= header[27:0` and then writes `(old & ~mask) | (data & mask)`, where mask is word 1 and data is word 2.
- R5: A poll keeps reading header[27:0] until `(rd & mask) == (expect & mask)`, where mask is word 1 and expect is word 2. A match ends the entry.
- R6: A poll that sees `poll_limit` mismatching reads in a row (at least one) ends the run with `done`=1 and `error`=1, and issues no further requests.
- R7: An indexed write issues `reg_indirect`=1, `reg_space`= header[27:20], `reg_addr`= header[19:0] zero-extended and `reg_wdata`= word 1.
- R8: A terminator ends the run with `done`=1, `error`=0 and `busy`=0. `exec_count` equals the number of non-terminator entries completed.
- R9: An unknown kind ends the run with `done`=1 and `error`=1, and causes no register access.
- R10: If an entry needs a word at table index ≥ `tbl_len`, the run ends with `done`=1 and `error`=1, and no read at that index is made.
- R11: Table word i is read at address `base_addr` + i. The data is taken one cycle after `tbl_rd_en`.
- R12: While `reg_req`=1 and `reg_ack`=0, the request and all its fields stay unchanged on the next cycle, for any number of wait cycles.
- R13: A `start` while `busy` is ignored. An accepted `start` clears `done`, `error` and `exec_count` and latches `base_addr`, `tbl_len` and `poll_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| base_addr | input | AW | Table base word address |
| tbl_len | input | AW+1 | Table length in words |
| poll_limit | input | TW | Mismatching reads allowed per poll |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | AW | Table word address |
| tbl_rd_data | input | 32 | Table data, one cycle after strobe |
| reg_req | output | 1 | Register request (valid) |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_indirect | output | 1 | Indexed-space access |
| reg_space | output | 8 | Index space select |
| reg_addr | output | 28 | Register offset |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Request accepted (ready) |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| error | output | 1 | Run ended abnormally |
| exec_count | output | CW | Completed commands |

## Verification
A wrong table pointer shows up within one entry. Either a register value does not match the arithmetic expectation, or the run ends with `error` from a bogus header or an overrun. A bad merge or a bad match shows up as a wrong final register value or a wrong count of poll reads, and each poll read is visible on the bus. A fault in the terminal flags or the counter shows up at `done` and `exec_count` as soon as the run ends. The tests sweep responder wait states from zero to three cycles, so any loss of request fields under stalls appears as a wrong address or data.

// File: rtl/cmdtab_pkg.sv
package cmdtab_pkg;
  typedef enum logic [3:0] {
    CK_WRITE = 4'h0,
    CK_POLL  = 4'h2,
    CK_RMW   = 4'h3,
    CK_IDXWR = 4'h8,
    CK_TERM  = 4'hF
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_WRITE,
    ST_READ,
    ST_POLL,
    ST_NEXT
  } seq_state_t;
endpackage

// File: rtl/cmdtab_decode.sv
module cmdtab_decode
  import cmdtab_pkg::*;
(
  input  logic [31:0] hdr,
  output logic        known,
  output cmd_kind_t   kind,
  output logic [1:0]  nwords,
  output logic [27:0] addr,
  output logic [7:0]  space,
  output logic        indexed
);
  always_comb begin
    kind    = cmd_kind_t'(hdr[31:28]);
    known   = 1'b1;
    nwords  = 2'd1;
    indexed = 1'b0;
    addr    = hdr[27:0];
    space   = 8'h00;
    case (hdr[31:28])
      4'h0:    nwords = 2'd2;
      4'h2:    nwords = 2'd3;
      4'h3:    nwords = 2'd3;
      4'h8: begin
        nwords  = 2'd2;
        indexed = 1'b1;
        addr    = {8'h00, hdr[19:0]};
        space   = hdr[27:20];
      end
      4'hF:    nwords = 2'd1;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmdtab_merge.sv
module cmdtab_merge (
  input  logic [31:0] old_val,
  input  logic [31:0] mask,
  input  logic [31:0] data,
  output logic [31:0] merged,
  output logic        match
);
  assign merged = (old_val & ~mask) | (data & mask);
  assign match  = ((old_val ^ data) & mask) == 32'h0;
endmodule

// File: rtl/cmdtab_poll_timer.sv
module cmdtab_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          miss,
  input  logic [TW-1:0] limit,
  output logic          last_try
);
  logic [TW-1:0] cnt;

  assign last_try = ({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (miss && !last_try) cnt <= cnt + TW'(1);
  end

  // R6
  miss_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !last_try && !clr) |=> (cnt != '0));
endmodule

// File: rtl/cmdtab_seq.sv
module cmdtab_seq
  import cmdtab_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   tbl_len,
  input  logic [TW-1:0] poll_limit,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_rd_addr,
  input  logic [31:0]   tbl_rd_data,
  output logic          reg_req,
  output logic          reg_we,
  output logic          reg_indirect,
  output logic [7:0]    reg_space,
  output logic [27:0]   reg_addr,
  output logic [31:0]   reg_wdata,
  input  logic          reg_ack,
  input  logic [31:0]   reg_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] exec_count
);
  localparam int PW = AW + 2;

  seq_state_t    state;
  logic [AW-1:0] base_q;
  logic [AW:0]   len_q;
  logic [TW-1:0] lim_q;
  logic [PW-1:0] ptr;
  logic [1:0]    idx;
  logic [31:0]   w0, w1, w2, wdata_q;
  logic          done_q, err_q;
  logic [CW-1:0] cnt;

  logic [PW-1:0] cur;
  logic          overrun;
  logic [31:0]   dec_in;
  logic          dec_known, dec_indexed;
  cmd_kind_t     dec_kind;
  logic [1:0]    dec_nwords;
  logic [27:0]   dec_addr;
  logic [7:0]    dec_space;
  logic [31:0]   merged;
  logic          match;
  logic          poll_clr, poll_miss, last_try;

  assign cur     = ptr + PW'(idx);
  assign overrun = cur >= PW'(len_q);
  assign dec_in  = (state == ST_CAPT && idx == 2'd0) ? tbl_rd_data : w0;

  cmdtab_decode u_decode (
    .hdr    (dec_in),
    .known  (dec_known),
    .kind   (dec_kind),
    .nwords (dec_nwords),
    .addr   (dec_addr),
    .space  (dec_space),
    .indexed(dec_indexed)
  );

  cmdtab_merge u_merge (
    .old_val(reg_rdata),
    .mask   (w1),
    .data   (w2),
    .merged (merged),
    .match  (match)
  );

  assign poll_clr  = (state == ST_CAPT);
  assign poll_miss = (state == ST_POLL) && reg_ack && !match;

  cmdtab_poll_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (poll_clr),
    .miss    (poll_miss),
    .limit   (lim_q),
    .last_try(last_try)
  );

  assign tbl_rd_en    = (state == ST_FETCH) && !overrun;
  assign tbl_rd_addr  = base_q + cur[AW-1:0];
  assign reg_req      = (state == ST_WRITE) || (state == ST_READ) || (state == ST_POLL);
  assign reg_we       = (state == ST_WRITE);
  assign reg_indirect = dec_indexed;
  assign reg_space    = dec_space;
  assign reg_addr     = dec_addr;
  assign reg_wdata    = wdata_q;
  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign error        = err_q;
  assign exec_count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      lim_q   <= '0;
      ptr     <= '0;
      idx     <= '0;
      w0      <= '0;
      w1      <= '0;
      w2      <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          base_q <= base_addr;
          len_q  <= tbl_len;
          lim_q  <= poll_limit;
          ptr    <= '0;
          idx    <= '0;
          cnt    <= '0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          state  <= ST_FETCH;
        end
        ST_FETCH: if (overrun) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          state  <= ST_IDLE;
        end else begin
          state <= ST_CAPT;
        end
        ST_CAPT: begin
          case (idx)
            2'd0:    w0 <= tbl_rd_data;
            2'd1:    w1 <= tbl_rd_data;
            default: w2 <= tbl_rd_data;
          endcase
          if (idx == 2'd0 && !dec_known) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end else if (idx == 2'd0 && dec_kind == CK_TERM) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if ((idx + 2'd1) < dec_nwords) begin
            idx   <= idx + 2'd1;
            state <= ST_FETCH;
          end else begin
            wdata_q <= tbl_rd_data;
            case (dec_kind)
              CK_RMW:  state <= ST_READ;
              CK_POLL: state <= ST_POLL;
              default: state <= ST_WRITE;
            endcase
          end
        end
        ST_WRITE: if (reg_ack) state <= ST_NEXT;
        ST_READ: if (reg_ack) begin
          wdata_q <= merged;
          state   <= ST_WRITE;
        end
        ST_POLL: if (reg_ack) begin
          if (match) begin
            state <= ST_NEXT;
          end else if (last_try) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_NEXT: begin
          ptr   <= ptr + PW'(dec_nwords);
          idx   <= '0;
          cnt   <= cnt + CW'(1);
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr)
                               && $stable(reg_wdata) && $stable(reg_space)));
  // R13
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && exec_count != '0) |=> (exec_count != '0));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R11
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> (busy && !reg_req));
  // R6
  poll_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL && reg_ack && !match && last_try) |=> (error && !reg_req));
endmodule

// File: tb/cmdtab_seq_bench.sv
module cmdtab_seq_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int TW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0] tbl_len = '0;
  logic [TW-1:0] poll_limit = '0;
  logic tbl_rd_en, reg_req, reg_we, reg_indirect, reg_ack;
  logic [AW-1:0] tbl_rd_addr;
  logic [31:0] tbl_rd_data, reg_wdata, reg_rdata;
  logic [7:0] reg_space;
  logic [27:0] reg_addr;
  logic busy, done, error;
  logic [CW-1:0] exec_count;

  always #(CLK_NS/2) clk = ~clk;

  cmdtab_seq #(.AW(AW), .TW(TW), .CW(CW)) u_cmdtab_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .tbl_len(tbl_len), .poll_limit(poll_limit), .tbl_rd_en(tbl_rd_en),
    .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data), .reg_req(reg_req),
    .reg_we(reg_we), .reg_indirect(reg_indirect), .reg_space(reg_space),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .error(error),
    .exec_count(exec_count)
  );

  logic [31:0] mem [256];
  always_ff @(posedge clk) tbl_rd_data <= mem[tbl_rd_addr];

  logic        clr_stats = 1'b0;
  logic [1:0]  wait_cfg = '0;
  logic [1:0]  wc;
  logic [31:0] regs [16];
  logic [31:0] pollctr;
  int          n_acc, n_wr, n_rd, max_idx;
  logic [7:0]  li_space;
  logic [27:0] li_addr;
  logic [31:0] li_data;

  assign reg_rdata = (reg_addr[3:0] == 4'hF) ? pollctr : regs[reg_addr[3:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_stats) begin
      reg_ack <= 1'b0; wc <= '0; pollctr <= '0;
      n_acc <= 0; n_wr <= 0; n_rd <= 0; max_idx <= -1;
      li_space <= '0; li_addr <= '0; li_data <= '0;
    end else begin
      if (reg_ack) begin
        reg_ack <= 1'b0; wc <= '0;
      end else if (reg_req) begin
        if (wc == wait_cfg) reg_ack <= 1'b1;
        else wc <= wc + 2'd1;
      end
      if (reg_req && reg_ack) begin
        n_acc <= n_acc + 1;
        if (reg_we) begin
          n_wr <= n_wr + 1;
          if (reg_indirect) begin
            li_space <= reg_space; li_addr <= reg_addr; li_data <= reg_wdata;
          end else begin
            regs[reg_addr[3:0]] <= reg_wdata;
          end
        end else begin
          n_rd <= n_rd + 1;
          if (reg_addr[3:0] == 4'hF) pollctr <= pollctr + 1;
        end
      end
      if (tbl_rd_en && int'(tbl_rd_addr - base_addr) > max_idx)
        max_idx <= int'(tbl_rd_addr - base_addr);
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [3:0] k, input logic [27:0] off);
    return {k, off};
  endfunction

  task automatic run(input logic [AW-1:0] b, input int len, input int lim, input logic [1:0] w);
    int n = 0;
    @(negedge clk);
    clr_stats = 1'b1; wait_cfg = w;
    base_addr = b; tbl_len = (AW+1)'(len); poll_limit = TW'(lim);
    @(negedge clk);
    clr_stats = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R13: accepted start clears done and raises busy
    check(busy && !done, "R13 start accepted", {busy, done}, 2'b10);
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) check(1'b0, "watchdog", n, 0);
  endtask

  initial begin
    logic [31:0] a, m, d, bv, expv;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !error && !reg_req && !tbl_rd_en && exec_count == 0,
          "R1 reset", {busy, done, error, reg_req, tbl_rd_en}, 0);
    rst_n = 1'b1;

    for (int w = 0; w < 4; w++) begin
      logic [AW-1:0] b = AW'(4 * w);
      a = 32'hCAFE_0000 + w; m = 32'h0000_FFFF; d = 32'h1234_5678 ^ (w << 4);
      bv = 32'hBEEF_0000 | w;
      expv = (a & ~m) | (d & m);
      mem[b+0] = hdr(4'h0, 28'd1); mem[b+1] = a;
      mem[b+2] = hdr(4'h3, 28'd1); mem[b+3] = m; mem[b+4] = d;
      mem[b+5] = {4'h8, 8'h5A, 20'h00ABC}; mem[b+6] = bv;
      mem[b+7] = hdr(4'h2, 28'd15); mem[b+8] = 32'hFFFF_FF00 | (w + 3); mem[b+9] = 32'hFF;
      mem[b+7] = hdr(4'h2, 28'd15); mem[b+8] = 32'h0000_00FF; mem[b+9] = 32'hAB00_0000 | (w + 3);
      mem[b+10] = hdr(4'hF, 28'd0);
      run(b, 11, 20, 2'(w));
      // R3, R4: written then merged register value
      check(regs[1] == expv, "R4 rmw merge", regs[1], expv);
      // R7
      check(li_space == 8'h5A && li_addr == 28'h00ABC && li_data == bv, "R7 indexed write",
            {li_space, li_addr, li_data}, {8'h5A, 28'h00ABC, bv});
      // R5: poll reads counter until it equals w+3
      check(pollctr == 32'(w + 4), "R5 poll reads", pollctr, w + 4);
      // R8, R2
      check(done && !error && !busy && exec_count == 4, "R8 end of table", {error, exec_count}, 4);
      check(n_wr == 3 && n_rd == w + 5, "R2 access count", {n_wr, n_rd}, {32'd3, 32'(w + 5)});
      // R11
      check(max_idx == 10, "R11 table span", max_idx, 10);
    end

    // R3: plain write with no merge
    mem[0] = hdr(4'h0, 28'd6); mem[1] = 32'h0A0B_0C0D; mem[2] = hdr(4'hF, 28'd0);
    run(8'd0, 3, 1, 2'd1);
    check(regs[6] == 32'h0A0B_0C0D && exec_count == 1, "R3 direct write", regs[6], 32'h0A0B_0C0D);

    // R9: unknown kind after one write
    mem[0] = hdr(4'h0, 28'd3); mem[1] = 32'h3333_3333; mem[2] = hdr(4'h5, 28'd3);
    run(8'd0, 3, 1, 2'd0);
    check(done && error && exec_count == 1 && n_acc == 1, "R9 unknown kind",
          {error, exec_count, n_acc}, {1'b1, 8'd1, 32'd1});

    // R10: second entry runs past length 4
    mem[0] = hdr(4'h0, 28'd2); mem[1] = 32'h2222_0001;
    mem[2] = hdr(4'h3, 28'd2); mem[3] = 32'hFFFF_FFFF; mem[4] = 32'h0;
    run(8'd0, 4, 1, 2'd2);
    check(done && error && exec_count == 1 && regs[2] == 32'h2222_0001, "R10 overrun flags",
          {error, exec_count}, {1'b1, 8'd1});
    check(max_idx == 3 && n_acc == 1, "R10 no read past end", max_idx, 3);

    // R6: poll never matches, limit 5
    mem[0] = hdr(4'h2, 28'd15); mem[1] = 32'h80; mem[2] = 32'h80; mem[3] = hdr(4'hF, 28'd0);
    run(8'd0, 4, 5, 2'd1);
    check(done && error && exec_count == 0 && n_rd == 5, "R6 poll timeout",
          {error, n_rd}, {1'b1, 32'd5});
    repeat (5) @(negedge clk);
    check(n_acc == 5 && !reg_req, "R6 no further access", n_acc, 5);

    // R8: terminator only
    mem[40] = hdr(4'hF, 28'h123);
    run(8'd40, 1, 1, 2'd0);
    check(done && !error && exec_count == 0 && n_acc == 0, "R8 empty table", {error, exec_count}, 0);

    // R13: start while busy ignored
    mem[100] = hdr(4'h2, 28'd15); mem[101] = 32'hFF; mem[102] = 32'h6;
    mem[103] = hdr(4'h0, 28'd4); mem[104] = 32'h4444_4444; mem[105] = hdr(4'hF, 28'd0);
    @(negedge clk);
    clr_stats = 1'b1; wait_cfg = 2'd3; base_addr = 8'd100; tbl_len = 9'd6; poll_limit = 8'd50;
    @(negedge clk);
    clr_stats = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = 8'd40; tbl_len = 9'd1;
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 3000) begin @(negedge clk); n++; end
      if (!done) check(1'b0, "watchdog", n, 0);
    end
    check(!error && exec_count == 2 && regs[4] == 32'h4444_4444 && pollctr == 7,
          "R13 busy start ignored", {exec_count, pollctr}, {8'd2, 32'd7});
    // R13: next accepted start clears count (terminator-only table at 40)
    run(8'd40, 1, 1, 2'd0);
    check(exec_count == 0 && done && !error, "R13 count cleared", exec_count, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule